// File: doc/BRIEF.md
# Bridge Egress Decision Unit

This block decides, once per frame, where a multi-port bridge sends the frame. It takes the frame's destination host address and the number of the port it arrived on, looks the address up in a small fully associative table of host-to-port bindings, and returns an egress port mask one clock later. The mask selects a single port when the host is known to live on another port, every other port when the host is unknown or the address is broadcast, and no port at all when the host lives on the arrival segment.

The table is filled and emptied through a write port, one entry per cycle, addressed by slot index. A separate per-port blocked vector, driven by whatever loop-avoidance logic surrounds the bridge, takes a port out of every mask and causes frames arriving on that port to be dropped. Frame storage and learning policy live outside the block.

Top module: `brfwd_top`

## Requirements
- R1: While reset is held and until a request is presented after it, `dec_valid` is 0; after reset every table slot is empty, so every lookup misses.
- R2: A request accepted on a clock edge with `req_valid` high yields `dec_valid` high with its mask and hit flag exactly one cycle later; with no request, `dec_valid` is 0 in the following cycle.
- R3: When the destination matches a valid entry whose port differs from the arrival port, `dec_hit` is 1 and the mask has only that port's bit set (bit i of the mask stands for port i).
- R4: When the destination matches a valid entry whose port equals the arrival port, `dec_hit` is 1 and the mask is all zeros (discard).
- R5: When the destination matches no valid entry, `dec_hit` is 0 and the mask has every port bit set except the arrival port's.
- R6: The all-ones destination is broadcast: `dec_hit` is 0 and the mask is every port except the arrival port, even when a table entry holds the all-ones address.
- R7: A port whose `blk_mask` bit is 1 is cleared in every mask; a hit on such a port yields an all-zero mask.
- R8: A frame arriving on a port whose `blk_mask` bit is 1 gets an all-zero mask.
- R9: A write with `wr_en` high and `wr_valid` high stores address and port in slot `wr_idx`, and with `wr_valid` low empties that slot; the change is seen by requests from the next cycle on, while a request in the same cycle as the write sees the old contents.
- R10: When several valid entries hold the destination, the one in the lowest-numbered slot decides the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Slot to write |
| wr_valid | input | 1 | 1 installs the entry, 0 empties the slot |
| wr_addr | input | 48 | Host address to store |
| wr_port | input | 2 | Port on which that host lives |
| blk_mask | input | 4 | Per-port blocked bits |
| req_valid | input | 1 | Decision request strobe |
| req_dst | input | 48 | Frame destination address |
| req_port | input | 2 | Frame arrival port |
| dec_valid | output | 1 | Decision available |
| dec_mask | output | 4 | Egress port mask, all zeros means discard |
| dec_hit | output | 1 | Destination found in the table |

## Verification
The hardest case to reach from the ports is a request and a table write landing on the same clock edge for the same address, where the decision must reflect the table before the write. The bench drives both in one cycle, then repeats the request alone in the next cycle so that the old and new views are both compared. Duplicate entries for one address are set up deliberately with different ports so that slot priority shows in the mask, and an all-ones entry is installed to prove broadcast never matches.

// File: rtl/brfwd_pkg.sv
package brfwd_pkg;

  localparam int unsigned DEF_PORTS  = 4;
  localparam int unsigned DEF_ADDR_W = 48;
  localparam int unsigned DEF_DEPTH  = 8;

  // Class of a per-frame decision
  typedef enum logic [1:0] {
    ACT_DROP  = 2'd0,
    ACT_UNI   = 2'd1,
    ACT_FLOOD = 2'd2
  } fwd_act_e;

endpackage

// File: rtl/brfwd_table.sv
module brfwd_table #(
  parameter int unsigned DEPTH  = brfwd_pkg::DEF_DEPTH,
  parameter int unsigned ADDR_W = brfwd_pkg::DEF_ADDR_W,
  parameter int unsigned PORT_W = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PORT_W-1:0] port_q [DEPTH];
  logic [DEPTH-1:0]  match;

  // Valid bits: next state
  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && wr_valid && (wr_idx == IDX_W'(g));

      // Payload carries no reset; only written when installed
      always_ff @(posedge clk) begin
        if (sel) begin
          addr_q[g] <= wr_addr;
          port_q[g] <= wr_port;
        end
      end

      assign match[g] = vld_q[g] && (addr_q[g] == lk_addr);
    end
  endgenerate

  // Lowest slot wins among several matches
  always_comb begin
    lk_hit  = 1'b0;
    lk_port = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        lk_port = port_q[i];
      end
    end
  end

  // An installed slot is valid on the next edge (R9)
  p_install_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |=> vld_q[$past(wr_idx)]);

  // An emptied slot never matches afterwards (R9)
  p_remove_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> !match[$past(wr_idx)]);

endmodule

// File: rtl/brfwd_decide.sv
module brfwd_decide
  import brfwd_pkg::*;
#(
  parameter int unsigned NPORTS = DEF_PORTS,
  localparam int unsigned PORT_W = $clog2(NPORTS)
) (
  input  logic              is_bcast,
  input  logic              lk_hit,
  input  logic [PORT_W-1:0] lk_port,
  input  logic [PORT_W-1:0] in_port,
  input  logic [NPORTS-1:0] blk,
  output logic [NPORTS-1:0] mask,
  output logic              hit
);

  fwd_act_e          act;
  logic [NPORTS-1:0] arr_oh;
  logic [NPORTS-1:0] dst_oh;
  logic [NPORTS-1:0] open_ports;

  always_comb begin
    arr_oh          = '0;
    arr_oh[in_port] = 1'b1;
    dst_oh          = '0;
    dst_oh[lk_port] = 1'b1;
    open_ports      = ~blk;
  end

  // Classify the frame
  always_comb begin
    if (blk[in_port])              act = ACT_DROP;
    else if (is_bcast)             act = ACT_FLOOD;
    else if (!lk_hit)              act = ACT_FLOOD;
    else if (lk_port == in_port)   act = ACT_DROP;
    else                           act = ACT_UNI;
  end

  always_comb begin
    unique case (act)
      ACT_UNI:   mask = dst_oh & open_ports;
      ACT_FLOOD: mask = ~arr_oh & open_ports;
      default:   mask = '0;
    endcase
    hit = lk_hit && !is_bcast;
  end

endmodule

// File: rtl/brfwd_top.sv
module brfwd_top
  import brfwd_pkg::*;
#(
  parameter int unsigned NPORTS = DEF_PORTS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned PORT_W = $clog2(NPORTS),
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [NPORTS-1:0] blk_mask,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [PORT_W-1:0] req_port,
  output logic              dec_valid,
  output logic [NPORTS-1:0] dec_mask,
  output logic              dec_hit
);

  // Reset: asserted at once, released after two edges
  logic [1:0] rst_ff;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q_n = rst_ff[1];

  logic              lk_hit;
  logic [PORT_W-1:0] lk_port;
  logic              is_bcast;
  logic [NPORTS-1:0] mask_c;
  logic              hit_c;

  assign is_bcast = &req_dst;

  brfwd_table #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_port  (wr_port),
    .lk_addr  (req_dst),
    .lk_hit   (lk_hit),
    .lk_port  (lk_port)
  );

  brfwd_decide #(
    .NPORTS (NPORTS)
  ) u_decide (
    .is_bcast (is_bcast),
    .lk_hit   (lk_hit),
    .lk_port  (lk_port),
    .in_port  (req_port),
    .blk      (blk_mask),
    .mask     (mask_c),
    .hit      (hit_c)
  );

  // Output stage: next state
  logic              vld_d;
  logic [NPORTS-1:0] mask_d;
  logic              hit_d;

  always_comb begin
    vld_d  = req_valid;
    mask_d = dec_mask;
    hit_d  = dec_hit;
    if (req_valid) begin
      mask_d = mask_c;
      hit_d  = hit_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dec_valid <= 1'b0;
      dec_mask  <= '0;
      dec_hit   <= 1'b0;
    end else begin
      dec_valid <= vld_d;
      dec_mask  <= mask_d;
      dec_hit   <= hit_d;
    end
  end

  // R2: one decision per request, one cycle later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> dec_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !dec_valid);

  // R5/R6: arrival port never appears in the mask
  p_no_echo_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> !dec_mask[$past(req_port)]);

  // R7: blocked ports never appear in the mask
  p_blocked_out_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> ((dec_mask & $past(blk_mask)) == '0));

  // R8: frames from a blocked port are dropped
  p_blocked_in_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && blk_mask[req_port]) |=> (dec_mask == '0));

  // R3: a known host is sent to one port at most
  p_uni_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid && dec_hit) |-> $onehot0(dec_mask));

  // R6: broadcast never reports a table hit
  p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && (&req_dst)) |=> !dec_hit);

endmodule

// File: tb/brfwd_top_tb.sv
module brfwd_top_tb;

  localparam int NP = 4;
  localparam int AW = 48;
  localparam int DP = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_idx;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [1:0]    wr_port;
  logic [NP-1:0] blk_mask;
  logic          req_valid;
  logic [AW-1:0] req_dst;
  logic [1:0]    req_port;
  logic          dec_valid;
  logic [NP-1:0] dec_mask;
  logic          dec_hit;

  brfwd_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_port   (wr_port),
    .blk_mask  (blk_mask),
    .req_valid (req_valid),
    .req_dst   (req_dst),
    .req_port  (req_port),
    .dec_valid (dec_valid),
    .dec_mask  (dec_mask),
    .dec_hit   (dec_hit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [NP-1:0] mask;
    logic          hit;
    int            due;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // Reference table kept by the bench
  bit          m_vld  [DP];
  logic [AW-1:0] m_addr [DP];
  logic [1:0]  m_port [DP];

  localparam logic [AW-1:0] BCAST = {AW{1'b1}};
  localparam logic [AW-1:0] HA = 48'h0000_1111_0001;
  localparam logic [AW-1:0] HB = 48'h0000_1111_0002;
  localparam logic [AW-1:0] HC = 48'h0000_1111_0003;
  localparam logic [AW-1:0] HD = 48'h0000_1111_0004;
  localparam logic [AW-1:0] HE = 48'h0000_1111_0005;
  localparam logic [AW-1:0] HZ = 48'h0000_9999_0000;

  task automatic predict(input logic [AW-1:0] dst, input logic [1:0] arr,
                         output logic [NP-1:0] m, output logic h);
    bit   found = 0;
    logic [1:0] p = '0;
    for (int i = 0; i < DP; i++) begin
      if (!found && m_vld[i] && m_addr[i] == dst) begin
        found = 1;
        p = m_port[i];
      end
    end
    if (dst == BCAST) found = 0;
    h = found;
    m = '0;
    if (blk_mask[arr]) m = '0;
    else if (found) begin
      if (p != arr && !blk_mask[p]) m[p] = 1'b1;
    end else begin
      for (int q = 0; q < NP; q++) if (q != arr && !blk_mask[q]) m[q] = 1'b1;
    end
  endtask

  task automatic push_req(input logic [AW-1:0] dst, input logic [1:0] arr, input string tag);
    exp_t e;
    predict(dst, arr, e.mask, e.hit);
    e.due = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1;
    req_dst   = dst;
    req_port  = arr;
  endtask

  task automatic set_wr(input int idx, input bit v, input logic [AW-1:0] a, input logic [1:0] p);
    wr_en    = 1'b1;
    wr_idx   = 3'(idx);
    wr_valid = v;
    wr_addr  = a;
    wr_port  = p;
  endtask

  task automatic commit_wr();
    if (wr_en) begin
      m_vld[wr_idx] = wr_valid;
      if (wr_valid) begin
        m_addr[wr_idx] = wr_addr;
        m_port[wr_idx] = wr_port;
      end
    end
  endtask

  // One cycle of stimulus then idle inputs
  task automatic step();
    @(negedge clk);
    commit_wr();
    wr_en     = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic req(input logic [AW-1:0] dst, input logic [1:0] arr, input string tag);
    push_req(dst, arr, tag);
    step();
  endtask

  task automatic wr(input int idx, input bit v, input logic [AW-1:0] a, input logic [1:0] p);
    set_wr(idx, v, a, p);
    step();
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (!dec_valid) begin
          failures++;
          $display("FAIL R2 %s dec_valid act=%b exp=1", e.tag, dec_valid);
        end
        checks++;
        if (dec_mask !== e.mask) begin
          failures++;
          $display("FAIL %s mask act=%b exp=%b", e.tag, dec_mask, e.mask);
        end
        checks++;
        if (dec_hit !== e.hit) begin
          failures++;
          $display("FAIL %s hit act=%b exp=%b", e.tag, dec_hit, e.hit);
        end
      end else if (dec_valid !== 1'b0) begin
        checks++;
        failures++;
        $display("FAIL R2 unexpected dec_valid act=%b exp=0", dec_valid);
      end
    end
  end

  initial begin
    for (int i = 0; i < DP; i++) m_vld[i] = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0;
    wr_addr = '0; wr_port = '0; blk_mask = '0;
    req_valid = 1'b0; req_dst = '0; req_port = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 dec_valid in reset act=%b exp=0", dec_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 dec_valid after reset act=%b exp=0", dec_valid);
    end

    // R1/R5: empty table floods
    req(HA, 2'd0, "R1");
    req(HZ, 2'd3, "R5");

    // R9: install entries
    wr(0, 1, HA, 2'd1);
    wr(1, 1, HB, 2'd2);
    wr(2, 1, HC, 2'd0);
    // R3 and R2 back to back
    req(HA, 2'd0, "R3");
    req(HB, 2'd3, "R3");
    req(HC, 2'd0, "R4");
    req(HB, 2'd2, "R4");
    req(HZ, 2'd1, "R5");

    // R6: broadcast, also with all-ones in the table
    req(BCAST, 2'd2, "R6");
    wr(3, 1, BCAST, 2'd1);
    req(BCAST, 2'd0, "R6");

    // R9: same-cycle write sees old contents, next cycle sees new
    set_wr(4, 1, HD, 2'd3);
    push_req(HD, 2'd0, "R9");
    step();
    req(HD, 2'd0, "R9");

    // R9: removal
    wr(0, 0, '0, 2'd0);
    req(HA, 2'd2, "R9");

    // R10: lowest slot wins
    wr(6, 1, HE, 2'd3);
    wr(5, 1, HE, 2'd1);
    req(HE, 2'd0, "R10");
    wr(5, 0, '0, 2'd0);
    req(HE, 2'd0, "R10");

    // R7: blocked egress
    blk_mask = 4'b1000;
    req(HD, 2'd0, "R7");
    req(HZ, 2'd1, "R7");
    req(BCAST, 2'd0, "R7");
    req(HB, 2'd1, "R7");

    // R8: blocked ingress
    blk_mask = 4'b0010;
    req(HB, 2'd1, "R8");
    req(BCAST, 2'd1, "R8");
    blk_mask = 4'b0000;
    req(HB, 2'd1, "R3");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R2 pending decisions act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule